// File: doc/BRIEF.md
# USB OUT Endpoint Data Toggle Checker

This block checks the DATA0/DATA1 sequence of data packets that arrive on the OUT endpoints of a USB device. It keeps one toggle bit for each endpoint. When the receive path reports a packet that arrived without errors, the block compares the packet's data PID with the toggle bit of the addressed endpoint.

A packet whose PID matches the toggle bit is passed on to the driver-side interface, and that endpoint's toggle bit then inverts. A packet whose PID does not match is taken to be a repeat of a packet that was already received. It is dropped without being reported and the toggle bit does not change. Every packet, including a dropped repeat, still gets a positive handshake, so the host stops retrying it. The handshake is NYET when the handshake-type input asks for it, and ACK in every other case.

Configuration strobes can force an endpoint's toggle bit back to DATA0. They can also set or clear a per-endpoint test inhibit. While the inhibit is set, the endpoint accepts every packet regardless of its PID and leaves its toggle bit alone.

Top module: `usb_out_toggle_chk`

## Requirements
- R1: After reset every endpoint expects DATA0, inhibit is clear on every endpoint, and deliver, discard, hsValid and hsNyet are all low.
- R2: pktPid encodes the data PID: 0 means DATA0 and 1 means DATA1. When pktValid is high and the PID equals the endpoint's toggle bit, deliver is high and discard is low in the cycle after.
- R3: When pktValid is high, inhibit is clear and the PID differs from the endpoint's toggle bit, discard is high and deliver is low in the cycle after.
- R4: Every cycle with pktValid high is followed by a cycle with hsValid high. In that cycle hsNyet is 1 (NYET) if nyetReq was high with the packet, and 0 (ACK) otherwise. This applies to discarded packets too.
- R5: A delivered packet with a matching toggle inverts that endpoint's toggle bit before the next cycle. A discarded packet leaves the bit unchanged.
- R6: The toggle bits of different endpoints are independent. A packet on one endpoint never changes another endpoint's toggle bit.
- R7: A cycle with cfgTogRst high forces the toggle bit of endpoint cfgEp to DATA0. If a packet on the same endpoint would invert the bit in that same cycle, the forced DATA0 wins.
- R8: While an endpoint's inhibit bit is set, every packet to that endpoint is delivered whatever its PID, and the endpoint's toggle bit stays unchanged.
- R9: A cycle with cfgInhWr high writes cfgInhVal into the inhibit bit of endpoint cfgEp. The new value governs packets from the next cycle onward. Once inhibit is cleared, checking resumes against the toggle value the endpoint held before the inhibit was set.
- R10: A cycle with pktValid low is followed by a cycle with deliver, discard, hsValid and hsNyet all low.
- R11: deliver and discard are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Strobe: a data packet without errors has arrived |
| pktEp | input | EP_W | Endpoint number of the packet |
| pktPid | input | 1 | Data PID of the packet: 0 = DATA0, 1 = DATA1 |
| nyetReq | input | 1 | Handshake type for this packet: 1 = NYET, 0 = ACK |
| cfgEp | input | EP_W | Endpoint addressed by the configuration strobes |
| cfgTogRst | input | 1 | Strobe: force the toggle of cfgEp to DATA0 |
| cfgInhWr | input | 1 | Strobe: write cfgInhVal into the inhibit bit of cfgEp |
| cfgInhVal | input | 1 | Inhibit value to write |
| deliver | output | 1 | Packet is reported to the driver side |
| discard | output | 1 | Packet is dropped silently as a repeat |
| hsValid | output | 1 | A handshake is to be sent |
| hsNyet | output | 1 | Handshake type: 1 = NYET, 0 = ACK |

## Verification
An internal toggle bit that is wrong stays hidden until the next packet arrives for that endpoint. That packet then shows the wrong choice between deliver and discard one cycle after its strobe. The bench therefore sends packet sequences that probe each endpoint's toggle bit again after every event that could have corrupted it: deliveries, repeats, forced resets, packets on other endpoints and inhibit periods. Handshake errors show up in the very next cycle, because each packet's handshake is compared cycle by cycle with a behavioural model.

// File: rtl/toggle_chk_pkg.sv
package toggle_chk_pkg;

  // Strobes from control to the toggle/inhibit store
  typedef struct packed {
    logic flip;     // invert toggle of the packet's endpoint
    logic clear;    // force toggle of cfgEp to DATA0
    logic inhWr;    // write inhibit bit of cfgEp
    logic inhVal;   // value for the inhibit write
  } togCmd_t;

  localparam logic PID_DATA0 = 1'b0;
  localparam logic PID_DATA1 = 1'b1;

endpackage

// File: rtl/toggle_chk_dp.sv
module toggle_chk_dp
  import toggle_chk_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EP_W-1:0] pktEp,
  input  logic [EP_W-1:0] cfgEp,
  input  togCmd_t         cmd,
  output logic            curTog,
  output logic            curInh
);

  logic [NUM_EP-1:0] togVec;
  logic [NUM_EP-1:0] inhVec;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hitPkt;
    logic hitCfg;
    assign hitPkt = (pktEp == EP_W'(i));
    assign hitCfg = (cfgEp == EP_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        togVec[i] <= PID_DATA0;
      end else if (cmd.clear && hitCfg) begin
        togVec[i] <= PID_DATA0;
      end else if (cmd.flip && hitPkt) begin
        togVec[i] <= ~togVec[i];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inhVec[i] <= 1'b0;
      end else if (cmd.inhWr && hitCfg) begin
        inhVec[i] <= cmd.inhVal;
      end
    end
  end

  logic epInRange;
  assign epInRange = (32'(pktEp) < NUM_EP);

  always_comb begin
    curTog = 1'b0;
    curInh = 1'b0;
    if (epInRange) begin
      curTog = togVec[pktEp];
      curInh = inhVec[pktEp];
    end
  end

endmodule

// File: rtl/toggle_chk_ctrl.sv
module toggle_chk_ctrl
  import toggle_chk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pktValid,
  input  logic    pktPid,
  input  logic    nyetReq,
  input  logic    cfgTogRst,
  input  logic    cfgInhWr,
  input  logic    cfgInhVal,
  input  logic    curTog,
  input  logic    curInh,
  output togCmd_t cmd,
  output logic    deliver,
  output logic    discard,
  output logic    hsValid,
  output logic    hsNyet
);

  logic pidMatch;
  logic accept;

  assign pidMatch = (pktPid == curTog);
  assign accept   = pktValid && (curInh || pidMatch);

  always_comb begin
    cmd        = '0;
    cmd.flip   = pktValid && !curInh && pidMatch;
    cmd.clear  = cfgTogRst;
    cmd.inhWr  = cfgInhWr;
    cmd.inhVal = cfgInhVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deliver <= 1'b0;
      discard <= 1'b0;
      hsValid <= 1'b0;
      hsNyet  <= 1'b0;
    end else begin
      deliver <= accept;
      discard <= pktValid && !accept;
      hsValid <= pktValid;
      hsNyet  <= pktValid && nyetReq;
    end
  end

endmodule

// File: rtl/usb_out_toggle_chk.sv
module usb_out_toggle_chk
  import toggle_chk_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pktValid,
  input  logic [EP_W-1:0] pktEp,
  input  logic            pktPid,
  input  logic            nyetReq,
  input  logic [EP_W-1:0] cfgEp,
  input  logic            cfgTogRst,
  input  logic            cfgInhWr,
  input  logic            cfgInhVal,
  output logic            deliver,
  output logic            discard,
  output logic            hsValid,
  output logic            hsNyet
);

  togCmd_t cmd;
  logic    curTog;
  logic    curInh;

  toggle_chk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pktValid  (pktValid),
    .pktPid    (pktPid),
    .nyetReq   (nyetReq),
    .cfgTogRst (cfgTogRst),
    .cfgInhWr  (cfgInhWr),
    .cfgInhVal (cfgInhVal),
    .curTog    (curTog),
    .curInh    (curInh),
    .cmd       (cmd),
    .deliver   (deliver),
    .discard   (discard),
    .hsValid   (hsValid),
    .hsNyet    (hsNyet)
  );

  toggle_chk_dp #(
    .NUM_EP (NUM_EP),
    .EP_W   (EP_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .pktEp  (pktEp),
    .cfgEp  (cfgEp),
    .cmd    (cmd),
    .curTog (curTog),
    .curInh (curInh)
  );

endmodule

// File: rtl/toggle_chk_sva.sv
module toggle_chk_sva (
  input logic clk,
  input logic rst_n,
  input logic pktValid,
  input logic pktPid,
  input logic nyetReq,
  input logic curTog,
  input logic curInh,
  input logic deliver,
  input logic discard,
  input logic hsValid,
  input logic hsNyet
);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(deliver && discard));

  a_r4_handshake_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |=> hsValid);

  a_r4_nyet_select: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |=> (hsNyet == $past(nyetReq)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pktValid |=> (!hsValid && !hsNyet && !deliver && !discard));

  a_r2_match_delivers: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && (pktPid == curTog)) |=> (deliver && !discard));

  a_r3_mismatch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && !curInh && (pktPid != curTog)) |=> (discard && !deliver));

  a_r8_inhibit_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && curInh) |=> deliver);

endmodule

bind usb_out_toggle_chk toggle_chk_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .pktValid (pktValid),
  .pktPid   (pktPid),
  .nyetReq  (nyetReq),
  .curTog   (curTog),
  .curInh   (curInh),
  .deliver  (deliver),
  .discard  (discard),
  .hsValid  (hsValid),
  .hsNyet   (hsNyet)
);

// File: tb/tb_usb_out_toggle_chk.sv
module tb_usb_out_toggle_chk;

  localparam int NUM_EP = 16;
  localparam int EP_W   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pktValid = 1'b0;
  logic [EP_W-1:0] pktEp = '0;
  logic            pktPid = 1'b0;
  logic            nyetReq = 1'b0;
  logic [EP_W-1:0] cfgEp = '0;
  logic            cfgTogRst = 1'b0;
  logic            cfgInhWr = 1'b0;
  logic            cfgInhVal = 1'b0;
  logic            deliver, discard, hsValid, hsNyet;

  int checks = 0;
  int fails  = 0;
  bit togM [NUM_EP];
  bit inhM [NUM_EP];

  always #10 clk = ~clk;

  usb_out_toggle_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) dut (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .pktEp(pktEp),
    .pktPid(pktPid), .nyetReq(nyetReq), .cfgEp(cfgEp), .cfgTogRst(cfgTogRst),
    .cfgInhWr(cfgInhWr), .cfgInhVal(cfgInhVal), .deliver(deliver),
    .discard(discard), .hsValid(hsValid), .hsNyet(hsNyet)
  );

  task automatic compare(input bit eDel, input bit eDis, input bit eHs,
                         input bit eNy, input string tag);
    checks++;
    if (deliver !== eDel || discard !== eDis || hsValid !== eHs || hsNyet !== eNy) begin
      fails++;
      $display("FAIL %s: del/dis/hs/nyet actual %b%b%b%b expected %b%b%b%b",
               tag, deliver, discard, hsValid, hsNyet, eDel, eDis, eHs, eNy);
    end
  endtask

  // One clock cycle: drive at negedge, model predicts, compare after the edge
  task automatic cyc(input bit v, input int ep, input bit pid, input bit ny,
                     input bit tr, input bit iw, input bit iv, input int cep,
                     input string tag);
    bit acc, eDel, eDis, eHs, eNy, flip;
    pktValid = v; pktEp = EP_W'(ep); pktPid = pid; nyetReq = ny;
    cfgTogRst = tr; cfgInhWr = iw; cfgInhVal = iv; cfgEp = EP_W'(cep);
    acc  = v && (inhM[ep] || (pid == togM[ep]));
    flip = v && !inhM[ep] && (pid == togM[ep]);
    eDel = acc; eDis = v && !acc; eHs = v; eNy = v && ny;
    if (flip) togM[ep] = !togM[ep];
    if (tr) togM[cep] = 1'b0;
    if (iw) inhM[cep] = iv;
    @(posedge clk);
    @(negedge clk);
    compare(eDel, eDis, eHs, eNy, tag);
  endtask

  task automatic pkt(input int ep, input bit pid, input bit ny, input string tag);
    cyc(1'b1, ep, pid, ny, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < NUM_EP; i++) begin togM[i] = 1'b0; inhM[i] = 1'b0; end
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset outputs");
    rst_n = 1'b1;
    idle("R10 idle after reset");
    // R1: every endpoint starts at DATA0
    for (int e = 0; e < NUM_EP; e++) pkt(e, 1'b0, 1'b0, "R1 DATA0 first");
    // R2/R5: ep3 now expects DATA1, then a repeat of DATA1 is dropped (R3)
    pkt(3, 1'b1, 1'b0, "R2 match DATA1");
    pkt(3, 1'b1, 1'b0, "R3 repeat dropped");
    pkt(3, 1'b1, 1'b1, "R4 NYET on dropped");
    pkt(3, 1'b0, 1'b1, "R5 toggle kept after drop");
    pkt(3, 1'b1, 1'b0, "R5 toggle flipped");
    // R6: ep5 activity leaves ep6 alone
    pkt(5, 1'b1, 1'b0, "R6 ep5 step");
    pkt(5, 1'b0, 1'b0, "R6 ep5 step");
    pkt(6, 1'b1, 1'b0, "R6 ep6 unchanged");
    // R7: forced DATA0, including collision with a matching packet
    cyc(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3, "R7 toggle reset");
    pkt(3, 1'b0, 1'b0, "R7 DATA0 after reset");
    cyc(1'b1, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3, "R7 reset beats flip");
    pkt(3, 1'b0, 1'b0, "R7 DATA0 expected");
    // R8: inhibit on ep7 (toggle 1), all PIDs accepted, toggle held
    cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7, "R9 inhibit write");
    pkt(7, 1'b0, 1'b0, "R8 inhibit accept DATA0");
    pkt(7, 1'b0, 1'b1, "R8 inhibit accept DATA0");
    pkt(7, 1'b1, 1'b0, "R8 inhibit accept DATA1");
    cyc(1'b1, 7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7, "R9 old inhibit governs");
    pkt(7, 1'b0, 1'b0, "R9 checking resumed");
    pkt(7, 1'b1, 1'b0, "R9 toggle held through inhibit");
    idle("R10 idle");
    idle("R10 idle");
    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      cyc(($urandom % 4) != 0, int'($urandom % NUM_EP), 1'($urandom),
          1'($urandom), ($urandom % 16) == 0, ($urandom % 16) == 0,
          1'($urandom), int'($urandom % NUM_EP), "R11 R5 mixed traffic");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule